// File: doc/BRIEF.md
# Selectable Digital Noise Rejection Filter

This block cleans one external interrupt/event input before it reaches edge detection and a timer event counter. The input arrives already synchronized to the core clock. A sample divider, advanced only on cycles where the cycle clock enable is high, takes one sample of the input every N enabled cycles. The ratio N is chosen by a 2-bit select as 1, 32 or 128. The filtered level follows the input only when two consecutive samples agree on the new value. At ratio N, any high or low phase lasting at least 2N enabled cycles therefore gets through. Any phase shorter than N enabled cycles is discarded.

The filtered level drives two single-cycle strobes, one for a rising and one for a falling change, which can feed a timer event input. It also drives an interrupt strobe whose sensitivity is chosen by a 2-bit edge mode: none, rising only, falling only, or both. Writing a new ratio select restarts the sample divider, so the first sample at the new ratio falls one full period after the change.

Top module: `nrf_filter`

## Requirements
- R1: After reset, the filtered level, both edge strobes and the interrupt strobe are low.
- R2: With select 2'b00 (ratio 1), a change of the input held for 2 enabled cycles appears on the filtered level at the second clock edge after the change, and a 1-cycle pulse of either polarity is discarded.
- R3: With select 2'b01 (ratio 32), an input phase of at least 64 enabled cycles is passed by its last cycle, and a phase of 31 cycles or fewer is discarded.
- R4: With select 2'b10 or 2'b11 (ratio 128), an input phase of at least 256 enabled cycles is passed by its last cycle, and a phase of 127 cycles or fewer is discarded.
- R5: The filtered level takes a new value only when two consecutive samples both equal that value, and that value matches the input at the edge where the level changes.
- R6: The rising (falling) strobe is high for exactly one cycle, in the same cycle that the filtered level first shows 1 (0). The two strobes are never high together, and the level never changes without one of them.
- R7: The interrupt strobe follows the edge mode: 2'b00 never fires, 2'b01 fires with the rising strobe, 2'b10 fires with the falling strobe, 2'b11 fires with either.
- R8: While the cycle clock enable is low, no sample is taken and the filtered level holds, whatever the input does.
- R9: A change of the select value restarts the divider. With select 2'b01 written at clock edge Q0 together with an input change, samples fall at Q32 and Q64, and the level changes at Q64 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Cycle clock enable; the divider advances only when high |
| din_i | input | 1 | Synchronized raw input level |
| ratio_sel_i | input | 2 | Sample ratio: 00 = 1, 01 = 32, 10/11 = 128 |
| edge_mode_i | input | 2 | Interrupt sensitivity: 00 none, 01 rising, 10 falling, 11 both |
| level_o | output | 1 | Filtered input level |
| rise_o | output | 1 | One-cycle strobe on a filtered rising change |
| fall_o | output | 1 | One-cycle strobe on a filtered falling change |
| irq_o | output | 1 | Interrupt strobe selected by the edge mode |

## Verification
A change of the ratio select can land in the same cycle as a sample tick that the old ratio would have produced. It can also land together with a change of the input. The bench provokes this by writing a new select in the same cycle that the input rises. The divider must discard the pending tick and count a full new period. The check is that the level is still low after the 64th edge and high right after it, exactly as the restart rule predicts. A second case makes a filtered change coincide with each edge mode. Each mode is judged by whether the interrupt strobe appears in the same cycle as the matching edge strobe.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

   // sample ratio select; both upper codes pick the slowest ratio
   typedef enum logic [1:0] {
      RATIO_FAST     = 2'b00,
      RATIO_MID      = 2'b01,
      RATIO_SLOW     = 2'b10,
      RATIO_SLOW_ALT = 2'b11
   } ratio_sel_e;

   // interrupt edge sensitivity
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

endpackage

// File: rtl/nrf_sample_div.sv
module nrf_sample_div
   import nrf_pkg::*;
#(
   parameter int DIV_MID  = 32,
   parameter int DIV_SLOW = 128,
   localparam int CNT_W   = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cyc_en_i,
   input  logic [1:0] ratio_sel_i,
   output logic       tick_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic [1:0]       sel_q;
   logic             sel_chg;

   // terminal count for the selected ratio
   always_comb begin
      case (ratio_sel_e'(ratio_sel_i))
         RATIO_FAST: limit = '0;
         RATIO_MID:  limit = CNT_W'(DIV_MID - 1);
         default:    limit = CNT_W'(DIV_SLOW - 1);
      endcase
   end

   assign sel_chg = (ratio_sel_i != sel_q);
   assign tick_o  = cyc_en_i && !sel_chg && (cnt_q == limit);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sel_q <= 2'b00;
      end else begin
         sel_q <= ratio_sel_i;
         if (sel_chg) begin
            cnt_q <= '0;
         end else if (cyc_en_i) begin
            if (cnt_q == limit) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/nrf_vote.sv
module nrf_vote #(
   parameter int VOTES = 2,
   localparam int HIST_W = VOTES - 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic din_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [HIST_W-1:0] hist_q;
   logic              agree_hi;
   logic              agree_lo;

   // sample history: a single register or a shift chain
   generate
      if (HIST_W == 1) begin : g_hist_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hist_q <= '0;
            end else if (tick_i) begin
               hist_q <= din_i;
            end
         end
      end else begin : g_hist_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hist_q <= '0;
            end else if (tick_i) begin
               hist_q <= {hist_q[HIST_W-2:0], din_i};
            end
         end
      end
   endgenerate

   assign agree_hi = din_i && (&hist_q);
   assign agree_lo = !din_i && !(|hist_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_o <= 1'b0;
         rise_o  <= 1'b0;
         fall_o  <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         if (tick_i) begin
            if (agree_hi && !level_o) begin
               level_o <= 1'b1;
               rise_o  <= 1'b1;
            end else if (agree_lo && level_o) begin
               level_o <= 1'b0;
               fall_o  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/nrf_edge_sel.sv
module nrf_edge_sel
   import nrf_pkg::*;
(
   input  logic [1:0] edge_mode_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       irq_o
);

   always_comb begin
      case (edge_mode_e'(edge_mode_i))
         EDGE_RISE: irq_o = rise_i;
         EDGE_FALL: irq_o = fall_i;
         EDGE_BOTH: irq_o = rise_i | fall_i;
         default:   irq_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/nrf_filter.sv
module nrf_filter #(
   parameter int DIV_MID  = 32,
   parameter int DIV_SLOW = 128,
   parameter int VOTES    = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cyc_en_i,
   input  logic       din_i,
   input  logic [1:0] ratio_sel_i,
   input  logic [1:0] edge_mode_i,
   output logic       level_o,
   output logic       rise_o,
   output logic       fall_o,
   output logic       irq_o
);

   // elaboration-time parameter checks
   generate
      if (DIV_MID < 2) begin : g_bad_mid
         $error("nrf_filter: DIV_MID must be at least 2");
      end
      if (DIV_SLOW <= DIV_MID) begin : g_bad_slow
         $error("nrf_filter: DIV_SLOW must exceed DIV_MID");
      end
      if (VOTES < 2) begin : g_bad_votes
         $error("nrf_filter: VOTES must be at least 2");
      end
   endgenerate

   logic tick;

   nrf_sample_div #(
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW)
   ) u_div (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cyc_en_i    (cyc_en_i),
      .ratio_sel_i (ratio_sel_i),
      .tick_o      (tick)
   );

   nrf_vote #(
      .VOTES (VOTES)
   ) u_vote (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .din_i   (din_i),
      .level_o (level_o),
      .rise_o  (rise_o),
      .fall_o  (fall_o)
   );

   nrf_edge_sel u_edge (
      .edge_mode_i (edge_mode_i),
      .rise_i      (rise_o),
      .fall_i      (fall_o),
      .irq_o       (irq_o)
   );

endmodule

// File: rtl/nrf_filter_chk.sv
module nrf_filter_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cyc_en_i,
   input logic       din_i,
   input logic [1:0] edge_mode_i,
   input logic       level_o,
   input logic       rise_o,
   input logic       fall_o,
   input logic       irq_o
);

   p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o && fall_o));

   p_rise_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (level_o && !$past(level_o)));

   p_fall_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> (!level_o && $past(level_o)));

   p_change_has_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o != $past(level_o)) |-> (rise_o || fall_o));

   p_change_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o != $past(level_o)) |-> $past(cyc_en_i));

   p_change_follows_din_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o != $past(level_o)) |-> ($past(din_i) == level_o));

   p_irq_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (rise_o || fall_o));

   p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i == 2'b00) |-> !irq_o);

endmodule

bind nrf_filter nrf_filter_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cyc_en_i    (cyc_en_i),
   .din_i       (din_i),
   .edge_mode_i (edge_mode_i),
   .level_o     (level_o),
   .rise_o      (rise_o),
   .fall_o      (fall_o),
   .irq_o       (irq_o)
);

// File: tb/tb_nrf_filter.sv
module tb_nrf_filter;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic       clk;
   logic       rst_n;
   logic       cyc_en;
   logic       din;
   logic [1:0] ratio_sel;
   logic [1:0] edge_mode;
   logic       level;
   logic       rise;
   logic       fall;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   int n_rise = 0;
   int n_fall = 0;
   int n_irq  = 0;
   int n_cyc  = 0;

   nrf_filter dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cyc_en_i    (cyc_en),
      .din_i       (din),
      .ratio_sel_i (ratio_sel),
      .edge_mode_i (edge_mode),
      .level_o     (level),
      .rise_o      (rise),
      .fall_o      (fall),
      .irq_o       (irq)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // strobe counters and watchdog
   always @(posedge clk) begin
      n_cyc <= n_cyc + 1;
      if (rise) n_rise <= n_rise + 1;
      if (fall) n_fall <= n_fall + 1;
      if (irq)  n_irq  <= n_irq + 1;
      if (n_cyc == WATCHDOG) begin
         $display("FAIL watchdog: actual %0d cycles expected < %0d", n_cyc, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cyc_en = 1'b1; din = 1'b0;
      ratio_sel = 2'b00; edge_mode = 2'b01;
      step(3);
      check("R1 level after reset", int'(level), 0);
      check("R1 strobes after reset", int'(rise | fall | irq), 0);
      rst_n = 1'b1;
      step(4);
      check("R1 level after release", int'(level), 0);
   endtask

   task automatic t_fast_edges;
      edge_mode = 2'b11;
      din = 1'b1;
      step(1);
      check("R2 level one edge after rise", int'(level), 0);
      step(1);
      check("R2 level two edges after rise", int'(level), 1);
      check("R6 rise strobe with level", int'(rise), 1);
      check("R7 irq both on rise", int'(irq), 1);
      step(1);
      check("R6 rise strobe one cycle", int'(rise), 0);
      din = 1'b0;
      step(1);
      check("R2 level one edge after fall", int'(level), 1);
      step(1);
      check("R2 level two edges after fall", int'(level), 0);
      check("R6 fall strobe with level", int'(fall), 1);
      step(1);
      check("R6 fall strobe one cycle", int'(fall), 0);
   endtask

   task automatic t_fast_glitch;
      int r0;
      int f0;
      r0 = n_rise;
      din = 1'b1; step(1); din = 1'b0;
      step(5);
      check("R2 high glitch level", int'(level), 0);
      check("R5 high glitch no rise", n_rise - r0, 0);
      din = 1'b1; step(4);
      f0 = n_fall;
      din = 1'b0; step(1); din = 1'b1;
      step(5);
      check("R2 low glitch level", int'(level), 1);
      check("R5 low glitch no fall", n_fall - f0, 0);
   endtask

   task automatic t_enable_hold;
      cyc_en = 1'b0; din = 1'b0;
      step(10);
      check("R8 level frozen with enable low", int'(level), 1);
      cyc_en = 1'b1;
      step(1);
      check("R8 first enabled edge", int'(level), 1);
      step(1);
      check("R8 second enabled edge", int'(level), 0);
   endtask

   task automatic t_mid;
      int r0;
      ratio_sel = 2'b01;
      step(40);
      r0 = n_rise;
      din = 1'b1; step(31); din = 1'b0;
      step(100);
      check("R3 31-cycle pulse level", int'(level), 0);
      check("R3 31-cycle pulse no rise", n_rise - r0, 0);
      din = 1'b1; step(64);
      check("R3 64-cycle high passed", int'(level), 1);
      din = 1'b0; step(64);
      check("R3 64-cycle low passed", int'(level), 0);
   endtask

   task automatic t_slow;
      int r0;
      ratio_sel = 2'b10;
      step(140);
      r0 = n_rise;
      din = 1'b1; step(127); din = 1'b0;
      step(300);
      check("R4 127-cycle pulse no rise", n_rise - r0, 0);
      din = 1'b1; step(256);
      check("R4 256-cycle high passed", int'(level), 1);
      ratio_sel = 2'b11;
      step(10);
      din = 1'b0; step(256);
      check("R4 256-cycle low passed code 11", int'(level), 0);
      step(20);
   endtask

   task automatic t_restart;
      ratio_sel = 2'b01; din = 1'b1;
      step(64);
      check("R9 level before second new sample", int'(level), 0);
      step(1);
      check("R9 level at second new sample", int'(level), 1);
      din = 1'b0; step(70);
      ratio_sel = 2'b00;
      step(4);
   endtask

   task automatic t_edge_modes;
      for (int m = 0; m < 4; m++) begin
         edge_mode = 2'(m);
         din = 1'b1; step(2);
         check($sformatf("R7 mode %0d irq on rise", m), int'(irq), int'(m[0]));
         step(2);
         din = 1'b0; step(2);
         check($sformatf("R7 mode %0d irq on fall", m), int'(irq), int'(m[1]));
         step(2);
      end
   endtask

   initial begin
      t_reset();
      t_fast_edges();
      t_fast_glitch();
      t_enable_hold();
      t_mid();
      t_slow();
      t_restart();
      t_edge_modes();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule